// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits on the device side of a byte-wide parallel NOR flash interface. It samples the active-low chip-enable, write-enable and output-enable strobes, the 16-bit address bus and the 8-bit data bus on a system clock. It turns the unlock-prefixed write sequences into operations on a small behavioural byte array. The operations are byte program, chip erase, identification entry and identification exit. A write phase is the interval in which chip-enable and write-enable are both low. A read phase is the interval in which chip-enable and output-enable are both low.

A program or erase starts an internal busy timer. For the length of that timer, reads return a status byte instead of array contents, and every write is ignored. In identification mode, reads return fixed code bytes. The array holds `2**ARRAY_AW` bytes. Address bits above that width alias onto the same bytes for reads and programs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The write address is taken in the clock cycle where a write phase begins. The write data is taken in the cycle where that phase ends, so an address change in the middle of a phase has no effect on the target.
- R2: `data_oe` is high in the cycle after one in which `ce_n` and `oe_n` were both sampled low, and low in every other cycle. The read byte is taken at the start of the read phase.
- R3: Byte program is the write sequence AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then one write of the data to the target address. Only address bits 14:0 are compared for the command writes. The new byte is ANDed into the stored byte.
- R4: The six-write sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h sets every byte to FFh.
- R5: The sequence AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. In that mode a read with address bit 0 low returns BFh, and a read with bit 0 high returns B4h. All other address bits are ignored.
- R6: Identification mode is left either by AAh@5555h, 55h@2AAAh, F0h@5555h, or by a single write of F0h to any address outside a program data write. After either form, reads return array contents.
- R7: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the programmed data, and 0 for an erase. Bit 6 is 1 on the first status read of an operation and then inverts on each further status read. Bits 5:0 are 0.
- R8: A write that does not match the next expected step returns the decoder to idle with no change to the array or to the mode.
- R9: A program is busy for `PROG_CYC` clock cycles and an erase for `ERASE_CYC` clock cycles, both counted from the cycle the final write phase ends. Every write made while busy is ignored.
- R10: Once busy has ended, reads return the true stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which the strobes are sampled |
| rst_n | input | 1 | Active-low synchronous reset; array resets to FFh |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 16 | Byte address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data towards the host |
| data_oe | output | 1 | High when the block drives the data bus; low means released (high impedance) |

## Verification
The bench first goes after the busy window boundary. It reads once in the last busy cycle and once in the first free cycle. A timer that is off by one returns true data too early, or status too late. It moves the address in the middle of a write phase, which exposes a decoder that latches at the wrong strobe edge. It checks the bit 6 toggle phase, which would reveal a design whose first status read returns 0. It also sends sequences broken at several steps, a full command stream written while busy, and unlock addresses that carry bit 15. A decoder that resumes half-way through, obeys writes while busy, or compares all 16 address bits would then program or erase bytes that must stay unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [14:0] UNLOCK_ADR_A = 15'h5555;
    localparam logic [14:0] UNLOCK_ADR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_FIRST    = 8'hAA;
    localparam logic [7:0]  KEY_SECOND   = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_PRE = 8'h80;
    localparam logic [7:0]  CMD_ERASE_ALL = 8'h10;
    localparam logic [7:0]  CMD_ID_ENTER = 8'h90;
    localparam logic [7:0]  CMD_ID_LEAVE = 8'hF0;
    localparam logic [7:0]  CODE_MAKER   = 8'hBF;
    localparam logic [7:0]  CODE_DEVICE  = 8'hB4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM,
        SQ_ERA3,
        SQ_ERA4,
        SQ_ERA5
    } seq_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE,
        OP_ID_ON,
        OP_ID_OFF
    } op_e;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_fire,
    input  logic [14:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        busy,
    output op_e         op,
    output seq_e        state
);

    typedef struct packed {
        seq_e st;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        logic hit_a;
        logic hit_b;
        d     = q;
        op    = OP_NONE;
        hit_a = (wr_addr == UNLOCK_ADR_A);
        hit_b = (wr_addr == UNLOCK_ADR_B);
        if (wr_fire && !busy) begin
            d.st = SQ_IDLE;
            if (q.st == SQ_PGM) begin
                op = OP_PROG;
            end else if (wr_data == CMD_ID_LEAVE) begin
                op = OP_ID_OFF;
            end else begin
                unique case (q.st)
                    SQ_IDLE: if (hit_a && wr_data == KEY_FIRST)  d.st = SQ_KEY1;
                    SQ_KEY1: if (hit_b && wr_data == KEY_SECOND) d.st = SQ_KEY2;
                    SQ_KEY2: begin
                        if (hit_a) begin
                            if (wr_data == CMD_PROGRAM)        d.st = SQ_PGM;
                            else if (wr_data == CMD_ERASE_PRE) d.st = SQ_ERA3;
                            else if (wr_data == CMD_ID_ENTER)  op   = OP_ID_ON;
                        end
                    end
                    SQ_ERA3: if (hit_a && wr_data == KEY_FIRST)  d.st = SQ_ERA4;
                    SQ_ERA4: if (hit_b && wr_data == KEY_SECOND) d.st = SQ_ERA5;
                    SQ_ERA5: if (hit_a && wr_data == CMD_ERASE_ALL) op = OP_ERASE;
                    default: d.st = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SQ_IDLE};
        else        q <= d;
    end

    assign state = q.st;

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int PROG_CYC  = 24,
    parameter int ERASE_CYC = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_erase)       cnt_d = CW'(ERASE_CYC);
        else if (start_prog)   cnt_d = CW'(PROG_CYC);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_store.sv
module flash_store #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic          erase_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (prog_en) begin
            mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ARRAY_AW  = 8,
    parameter int PROG_CYC  = 24,
    parameter int ERASE_CYC = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [15:0] addr,
    input  logic [7:0]  data_in,
    output logic [7:0]  data_out,
    output logic        data_oe
);

    typedef struct packed {
        logic        wr_act;
        logic        rd_act;
        logic [14:0] alat;
        logic [7:0]  rdata;
        logic        tog;
        logic        st7;
        logic        id;
    } top_regs_t;

    top_regs_t q, d;

    logic       wr_now, rd_now, wr_fire, rd_start;
    logic       busy, id_mode;
    logic [7:0] arr_rd;
    op_e        op;
    seq_e       seq_state;

    assign wr_now   = !ce_n && !we_n;
    assign rd_now   = !ce_n && !oe_n;
    assign wr_fire  = q.wr_act && !wr_now;
    assign rd_start = rd_now && !q.rd_act;
    assign id_mode  = q.id;

    flash_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_addr (q.alat),
        .wr_data (data_in),
        .busy    (busy),
        .op      (op),
        .state   (seq_state)
    );

    flash_busy_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (op == OP_PROG),
        .start_erase (op == OP_ERASE),
        .busy        (busy)
    );

    flash_store #(
        .AW (ARRAY_AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (op == OP_PROG),
        .prog_addr (q.alat[ARRAY_AW-1:0]),
        .prog_data (data_in),
        .erase_en  (op == OP_ERASE),
        .rd_addr   (addr[ARRAY_AW-1:0]),
        .rd_data   (arr_rd)
    );

    always_comb begin
        d        = q;
        d.wr_act = wr_now;
        d.rd_act = rd_now;
        if (wr_now && !q.wr_act) d.alat = addr[14:0];

        unique case (op)
            OP_PROG: begin
                d.tog = 1'b1;
                d.st7 = ~data_in[7];
            end
            OP_ERASE: begin
                d.tog = 1'b1;
                d.st7 = 1'b0;
            end
            OP_ID_ON:  d.id = 1'b1;
            OP_ID_OFF: d.id = 1'b0;
            default: ;
        endcase

        if (rd_start) begin
            if (busy) begin
                d.rdata = {q.st7, q.tog, 6'b0};
                d.tog   = ~q.tog;
            end else if (q.id) begin
                d.rdata = addr[0] ? CODE_DEVICE : CODE_MAKER;
            end else begin
                d.rdata = arr_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{wr_act: 1'b0, rd_act: 1'b0, alat: '0, rdata: '0,
                   tog: 1'b1, st7: 1'b0, id: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data_out = q.rdata;
    assign data_oe  = q.rd_act;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       data_oe,
    input logic [7:0] data_out,
    input logic       busy,
    input logic       wr_fire,
    input logic       rd_start,
    input logic       id_mode,
    input seq_e       seq_state
);

    assert_bus_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) || $past(oe_n)) |-> !data_oe);

    assert_bus_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ce_n) && !$past(oe_n)) |-> data_oe);

    assert_busy_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(seq_state) == SQ_PGM || $past(seq_state) == SQ_ERA5));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_fire) |=> ($stable(seq_state) && $stable(id_mode)));

    assert_id_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> ($past(seq_state) == SQ_KEY2));

    assert_status_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_start) |=> (data_out[5:0] == 6'b0 && data_oe));

endmodule

bind flash_cmd_decoder flash_cmd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .data_oe   (data_oe),
    .data_out  (data_out),
    .busy      (busy),
    .wr_fire   (wr_fire),
    .rd_start  (rd_start),
    .id_mode   (id_mode),
    .seq_state (seq_state)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    localparam int PROG_CYC  = 24;
    localparam int ERASE_CYC = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] mdl [256];

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ARRAY_AW(8), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] status_byte(input logic [7:0] d, input logic first);
        return {~d[7], first, 6'b0};
    endfunction

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; data_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = data_out; oe = data_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] v;
        logic oe;
        bus_rd(a, v, oe);
        chk({tag, " oe"}, {7'b0, oe}, 8'h01);
        chk(tag, v, exp);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(a, d);
        mdl[a[7:0]] = mdl[a[7:0]] & d;
    endtask

    task automatic id_enter();
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h90);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        logic [15:0] a;
        logic [7:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;

        wait_cyc(4);
        chk("reset R2 data_oe", {7'b0, data_oe}, 8'h00);
        rst_n = 1'b1;
        wait_cyc(1);
        rd_chk("reset R10 erased content", 16'h0005, 8'hFF);

        // R2: output released when only one of the two read strobes is low
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); chk("R2 ce only", {7'b0, data_oe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); chk("R2 oe only", {7'b0, data_oe}, 8'h00);
        oe_n = 1'b1;
        @(negedge clk); addr = 16'h0010; data_in = 8'h00; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); chk("R2 during write", {7'b0, data_oe}, 8'h00);
        we_n = 1'b1; ce_n = 1'b1;
        wait_cyc(2);
        rd_chk("R8 lone write no effect", 16'h0010, 8'hFF);

        // R3 and R7: program with status reads, then true data (R10)
        prog(16'h0021, 8'h5A);
        rd_chk("R7 first status", 16'h0021, status_byte(8'h5A, 1'b1));
        rd_chk("R7 second status", 16'h0021, status_byte(8'h5A, 1'b0));
        rd_chk("R7 third status", 16'h0021, status_byte(8'h5A, 1'b1));
        wait_cyc(PROG_CYC);
        rd_chk("R3 R10 programmed", 16'h0021, mdl[8'h21]);
        prog(16'h0021, 8'hF3);
        wait_cyc(PROG_CYC + 2);
        rd_chk("R3 AND into byte", 16'h0021, 8'h52);

        // R3: unlock addresses with bit 15 set are still accepted
        bus_wr(16'hD555, 8'hAA);
        bus_wr(16'hAAAA, 8'h55);
        bus_wr(16'hD555, 8'hA0);
        bus_wr(16'h0033, 8'h0F);
        mdl[8'h33] = 8'h0F;
        wait_cyc(PROG_CYC + 2);
        rd_chk("R3 bit15 ignored", 16'h0033, 8'h0F);

        // R1: address moves in the middle of the data write phase
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        @(negedge clk); addr = 16'h0040; data_in = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = 16'h0041;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        mdl[8'h40] = 8'h11;
        wait_cyc(PROG_CYC + 2);
        rd_chk("R1 start address used", 16'h0040, 8'h11);
        rd_chk("R1 late address untouched", 16'h0041, 8'hFF);

        // R9: busy window boundary
        prog(16'h0050, 8'h80);
        wait_cyc(PROG_CYC - 2);
        rd_chk("R9 last busy cycle", 16'h0050, status_byte(8'h80, 1'b1));
        prog(16'h0051, 8'h7E);
        wait_cyc(PROG_CYC - 1);
        rd_chk("R9 first free cycle", 16'h0051, 8'h7E);

        // R9: full command stream written while busy is ignored
        prog(16'h0060, 8'hC3);
        prog(16'h0061, 8'h00);
        mdl[8'h61] = 8'hFF;
        bus_wr(16'h0062, 8'hF0);
        wait_cyc(PROG_CYC + 2);
        rd_chk("R9 busy program ignored", 16'h0061, 8'hFF);
        rd_chk("R9 R10 first program", 16'h0060, 8'hC3);
        bus_wr(16'h0061, 8'h00);
        rd_chk("R9 decoder idle after", 16'h0061, 8'hFF);

        // R8: broken sequences
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h1234, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'h0070, 8'h00);
        rd_chk("R8 wrong address", 16'h0070, 8'hFF);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h77);
        bus_wr(16'h0070, 8'h00);
        rd_chk("R8 bad command", 16'h0070, 8'hFF);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h80);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h54);
        bus_wr(16'h5555, 8'h10);
        rd_chk("R8 erase broken", 16'h0021, mdl[8'h21]);

        // R5 and R6
        id_enter();
        rd_chk("R5 maker code", 16'h0000, 8'hBF);
        rd_chk("R5 device code", 16'h7F01, 8'hB4);
        bus_wr(16'h1234, 8'hF0);
        rd_chk("R6 single write exit", 16'h0021, mdl[8'h21]);
        id_enter();
        rd_chk("R5 re-entry", 16'h0002, 8'hBF);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hF0);
        rd_chk("R6 three write exit", 16'h0033, mdl[8'h33]);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = int'($urandom_range(0, 3));
            a = 16'($urandom());
            d = 8'($urandom());
            if (kind == 0) begin
                prog(a, d);
                rd_chk("R7 random status", a, status_byte(d, 1'b1));
                wait_cyc(PROG_CYC + 2);
                rd_chk("R3 random program", a, mdl[a[7:0]]);
            end else if (kind == 1) begin
                bus_wr(16'h5555, 8'hAA);
                bus_wr({1'b0, 15'h2AAA ^ 15'(1 << $urandom_range(0, 14))}, 8'h55);
                bus_wr(16'h5555, 8'hA0);
                bus_wr(a, d);
                rd_chk("R8 random break", a, mdl[a[7:0]]);
            end else if (kind == 2) begin
                id_enter();
                rd_chk("R5 random id", a, a[0] ? 8'hB4 : 8'hBF);
                bus_wr(16'($urandom()), 8'hF0);
                rd_chk("R6 random exit", a, mdl[a[7:0]]);
            end else begin
                rd_chk("R10 random read", a, mdl[a[7:0]]);
            end
        end

        // R4: chip erase with status
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h80);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h10);
        rd_chk("R7 erase status", 16'h0021, 8'h40);
        rd_chk("R7 erase status toggled", 16'h0021, 8'h00);
        wait_cyc(ERASE_CYC + 2);
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        rd_chk("R4 erased 21", 16'h0021, 8'hFF);
        rd_chk("R4 erased 40", 16'h0040, 8'hFF);
        rd_chk("R4 erased 60", 16'h0060, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule